// File: doc/BRIEF.md
# Operating Mode Request Checker and Interrupt Sources

This block sits beside a device's operating-mode sequencer. It judges each request to change the operating mode against the current mode, the sequencer's busy flag and a flag that reports a failed return from low power. Accepted requests are passed on to the sequencer as a one-cycle target pulse. Rejected requests are dropped, and the block records them as an invalid-mode event.

The block also watches two more conditions. One is the hardware fault line that forces the device into the safe mode. The other is the end of every mode transition. It keeps one pending bit for each of its three event sources and one mask bit for each. Software clears pending bits by writing ones and loads the mask with a single write.

A software safe strobe always issues a safe-mode target and is never counted as a fault. When it lands in the same cycle as a normal request, the strobe wins and the request is dropped unjudged. The sequencer itself is not part of this block. It is seen only through its busy flag and its current-mode value.

Top module: `mode_irq_ctrl`

## Requirements
- R1: A request whose target equals `cur_mode` is always accepted, even while `trans_busy` or `lp_exit_fail` is 1.
- R2: Mode codes are RESET=0, TEST=1, SAFE=2, DRUN=3, RUN0..RUN3=4..7, HALT0=8, STOP0=10. Codes 9 and 11..15 are rejected. A non-self request made while `trans_busy` is 1 is rejected.
- R3: While `lp_exit_fail` is 1, a non-self request is accepted only if its target is SAFE (2) or RESET (0). All other targets are rejected, including HALT0 and STOP0.
- R4: An accepted request gives `tgt_valid`=1 for one cycle after the sampling edge, with `tgt_mode` set to the target. A rejected request gives no pulse and sets `pend[0]` (invalid mode).
- R5: A rising edge of `hw_safe_req` sets `pend[1]` (safe fault). This includes a rising edge while `cur_mode` is already SAFE.
- R6: `sw_safe_req` issues a SAFE target (`tgt_valid`=1, `tgt_mode`=2) and never sets `pend[1]`.
- R7: A clear of `pend[1]` has no effect while `hw_safe_req` is 1.
- R8: A 1-to-0 edge of `trans_busy` sets `pend[2]` (transition complete), unless `cur_mode` is HALT0 (8) or STOP0 (10) in that cycle.
- R9: `clr_wr` with bit i of `clr_data` at 1 clears `pend[i]`. A set event and a clear of the same bit in the same cycle leave the bit at 1.
- R10: `mask_wr` loads `mask` from `mask_data`. `irq` is the OR over i of `pend[i] & mask[i]`, registered, so it follows `pend` by one cycle.
- R11: After reset, `pend`, `mask`, `irq` and `tgt_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Single-cycle mode request strobe |
| req_mode | input | 4 | Requested target mode |
| cur_mode | input | 4 | Current mode reported by the sequencer |
| trans_busy | input | 1 | Sequencer is in a transition |
| lp_exit_fail | input | 1 | Return from low power did not reach its run mode |
| hw_safe_req | input | 1 | Hardware fault request for the safe mode |
| sw_safe_req | input | 1 | Software safe-entry strobe |
| clr_wr | input | 1 | Write strobe for pending-bit clear |
| clr_data | input | 3 | Write-one-to-clear pattern |
| mask_wr | input | 1 | Write strobe for mask |
| mask_data | input | 3 | New mask value |
| tgt_valid | output | 1 | Accepted target pulse to the sequencer |
| tgt_mode | output | 4 | Last accepted target mode |
| pend | output | 3 | Pending bits: 0 invalid, 1 safe fault, 2 transition complete |
| mask | output | 3 | Mask bits, same positions as pend |
| irq | output | 1 | Combined registered interrupt |

## Verification
A source event and a software clear of the same pending bit can land on one clock edge. The bench provokes this in two ways: a hardware safe rising edge together with a clear of bit 1, and a busy falling edge together with a clear of bit 2. In both cases it expects the bit to read 1 afterwards, and it expects a later clear alone to empty the bit. A clear of the safe bit while the fault line is still high also coincides with a held source, and the bench judges it by reading the bit as unchanged.

// File: rtl/mode_irq_pkg.sv
package mode_irq_pkg;
    localparam int MODE_W  = 4;
    localparam int NUM_SRC = 3;

    localparam int SRC_INV  = 0;
    localparam int SRC_SAFE = 1;
    localparam int SRC_MTC  = 2;

    localparam logic [MODE_W-1:0] MD_RESET = 4'd0;
    localparam logic [MODE_W-1:0] MD_TEST  = 4'd1;
    localparam logic [MODE_W-1:0] MD_SAFE  = 4'd2;
    localparam logic [MODE_W-1:0] MD_DRUN  = 4'd3;
    localparam logic [MODE_W-1:0] MD_RUN0  = 4'd4;
    localparam logic [MODE_W-1:0] MD_RUN3  = 4'd7;
    localparam logic [MODE_W-1:0] MD_HALT0 = 4'd8;
    localparam logic [MODE_W-1:0] MD_STOP0 = 4'd10;

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        return (m <= MD_RUN3) || (m == MD_HALT0) || (m == MD_STOP0);
    endfunction

    function automatic logic mode_low_power(input logic [MODE_W-1:0] m);
        return (m == MD_HALT0) || (m == MD_STOP0);
    endfunction
endpackage

// File: rtl/mode_req_check.sv
module mode_req_check
    import mode_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic              trans_busy,
    input  logic              lp_exit_fail,
    input  logic              sw_safe_req,
    output logic              tgt_valid_o,
    output logic [MODE_W-1:0] tgt_mode_o,
    output logic              inv_evt_o
);
    typedef struct packed {
        logic              vld;
        logic [MODE_W-1:0] mode;
    } chk_t;

    chk_t chk_d, chk_q;
    logic is_self;
    logic escape_ok;
    logic req_ok;
    logic take_req;

    always_comb begin
        chk_d     = chk_q;
        is_self   = (req_mode == cur_mode);
        escape_ok = (req_mode == MD_SAFE) || (req_mode == MD_RESET);
        if (is_self)
            req_ok = 1'b1;
        else if (!mode_known(req_mode) || trans_busy)
            req_ok = 1'b0;
        else if (lp_exit_fail)
            req_ok = escape_ok;
        else
            req_ok = 1'b1;
        take_req  = req_valid && !sw_safe_req;
        inv_evt_o = take_req && !req_ok;
        chk_d.vld = 1'b0;
        if (sw_safe_req) begin
            chk_d.vld  = 1'b1;
            chk_d.mode = MD_SAFE;
        end else if (take_req && req_ok) begin
            chk_d.vld  = 1'b1;
            chk_d.mode = req_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '{vld: 1'b0, mode: MD_RESET};
        else        chk_q <= chk_d;
    end

    assign tgt_valid_o = chk_q.vld;
    assign tgt_mode_o  = chk_q.mode;

    // R1: a self request always goes through
    assert_self_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sw_safe_req && req_mode == cur_mode)
        |=> (tgt_valid_o && tgt_mode_o == $past(req_mode)));

    // R6: software safe strobe always targets SAFE
    assert_sw_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_safe_req |=> (tgt_valid_o && tgt_mode_o == MD_SAFE));
endmodule

// File: rtl/mode_evt_detect.sv
module mode_evt_detect
    import mode_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_safe_req,
    input  logic              trans_busy,
    input  logic [MODE_W-1:0] cur_mode,
    output logic              safe_evt_o,
    output logic              mtc_evt_o
);
    typedef struct packed {
        logic hw;
        logic busy;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d.hw   = hw_safe_req;
        edge_d.busy = trans_busy;
        safe_evt_o  = hw_safe_req && !edge_q.hw;
        mtc_evt_o   = edge_q.busy && !trans_busy && !mode_low_power(cur_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    // R5: a held fault line produces no repeated event
    assert_safe_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_safe_req && $past(hw_safe_req)) |-> !safe_evt_o);
endmodule

// File: rtl/mode_irq_regs.sv
module mode_irq_regs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] hold_clr,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_data,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_data,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] mask;
        logic         irq;
    } irq_regs_t;

    irq_regs_t regs_d, regs_q;
    logic [N-1:0] clr_eff;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < N; i++) begin
            clr_eff[i]     = clr_wr && clr_data[i] && !hold_clr[i];
            regs_d.pend[i] = set_evt[i] || (regs_q.pend[i] && !clr_eff[i]);
        end
        if (mask_wr) regs_d.mask = mask_data;
        regs_d.irq = |(regs_q.pend & regs_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pend_o = regs_q.pend;
    assign mask_o = regs_q.mask;
    assign irq_o  = regs_q.irq;

    for (genvar g = 0; g < N; g++) begin : g_bit_chk
        // R9: set beats clear
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[g] |=> pend_o[g]);
        // R7: clear blocked while source held
        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && hold_clr[g]) |=> pend_o[g]);
    end

    // R10: irq follows masked pending one cycle later
    assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_o & mask_o))));
endmodule

// File: rtl/mode_irq_ctrl.sv
module mode_irq_ctrl
    import mode_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic              trans_busy,
    input  logic              lp_exit_fail,
    input  logic              hw_safe_req,
    input  logic              sw_safe_req,
    input  logic              clr_wr,
    input  logic [NUM_SRC-1:0] clr_data,
    input  logic              mask_wr,
    input  logic [NUM_SRC-1:0] mask_data,
    output logic              tgt_valid,
    output logic [MODE_W-1:0] tgt_mode,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] mask,
    output logic              irq
);
    logic inv_evt, safe_evt, mtc_evt;
    logic [NUM_SRC-1:0] set_vec, hold_vec;

    mode_req_check u_check (
        .clk, .rst_n, .req_valid, .req_mode, .cur_mode, .trans_busy,
        .lp_exit_fail, .sw_safe_req,
        .tgt_valid_o(tgt_valid), .tgt_mode_o(tgt_mode), .inv_evt_o(inv_evt)
    );

    mode_evt_detect u_edges (
        .clk, .rst_n, .hw_safe_req, .trans_busy, .cur_mode,
        .safe_evt_o(safe_evt), .mtc_evt_o(mtc_evt)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[SRC_INV]   = inv_evt;
        set_vec[SRC_SAFE]  = safe_evt;
        set_vec[SRC_MTC]   = mtc_evt;
        hold_vec           = '0;
        hold_vec[SRC_SAFE] = hw_safe_req;
    end

    mode_irq_regs #(.N(NUM_SRC)) u_regs (
        .clk, .rst_n, .set_evt(set_vec), .hold_clr(hold_vec),
        .clr_wr, .clr_data, .mask_wr, .mask_data,
        .pend_o(pend), .mask_o(mask), .irq_o(irq)
    );

    // R3: after failed low-power exit, non-escape targets are flagged
    assert_lp_fail_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sw_safe_req && lp_exit_fail && req_mode != cur_mode &&
         req_mode != MD_SAFE && req_mode != MD_RESET)
        |=> (pend[SRC_INV] && !tgt_valid));

    // R4: a rejected request never reaches the sequencer
    assert_busy_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sw_safe_req && trans_busy && req_mode != cur_mode)
        |=> !tgt_valid);

    // R8: completion into a run mode is recorded
    assert_mtc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trans_busy) && !mode_low_power(cur_mode)) |=> pend[SRC_MTC]);

    // R8: completion into low power is not recorded
    assert_mtc_lp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trans_busy) && mode_low_power(cur_mode) && !pend[SRC_MTC])
        |=> !pend[SRC_MTC]);

    // R6: software safe entry alone never raises the fault bit
    assert_sw_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_safe_req && !hw_safe_req && !pend[SRC_SAFE]) |=> !pend[SRC_SAFE]);
endmodule

// File: tb/sim_mode_irq_ctrl.sv
module sim_mode_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, trans_busy = 0, lp_exit_fail = 0;
    logic hw_safe_req = 0, sw_safe_req = 0, clr_wr = 0, mask_wr = 0;
    logic [3:0] req_mode = 0, cur_mode = 0;
    logic [2:0] clr_data = 0, mask_data = 0;
    logic tgt_valid, irq;
    logic [3:0] tgt_mode;
    logic [2:0] pend, mask;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mode_irq_ctrl u0 (.*);

    // vector: [10:7] req, [6:3] cur, [2] busy, [1] lp fail, [0] expect accept
    localparam logic [10:0] VEC [0:10] = '{
        {4'd5, 4'd3, 1'b0, 1'b0, 1'b1},   // R2 plain accept
        {4'd4, 4'd4, 1'b1, 1'b0, 1'b1},   // R1 self while busy
        {4'd6, 4'd4, 1'b1, 1'b0, 1'b0},   // R2 busy reject
        {4'd2, 4'd8, 1'b0, 1'b1, 1'b1},   // R3 SAFE escape
        {4'd0, 4'd4, 1'b0, 1'b1, 1'b1},   // R3 RESET escape
        {4'd5, 4'd4, 1'b0, 1'b1, 1'b0},   // R3 run target rejected
        {4'd8, 4'd4, 1'b0, 1'b1, 1'b0},   // R3 back to low power rejected
        {4'd9, 4'd4, 1'b0, 1'b0, 1'b0},   // R2 unused code
        {4'd10,4'd7, 1'b0, 1'b0, 1'b1},   // R2 STOP0 accepted
        {4'd1, 4'd3, 1'b0, 1'b0, 1'b1},   // R2 TEST accepted
        {4'd4, 4'd4, 1'b0, 1'b1, 1'b1}    // R1 self with lp fail
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] bits);
        clr_wr = 1; clr_data = bits;
        tick();
        clr_wr = 0; clr_data = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 pend", pend, 0);
        chk("R11 mask", mask, 0);
        chk("R11 irq", irq, 0);
        chk("R11 tgt_valid", tgt_valid, 0);

        for (int i = 0; i < 11; i++) begin
            req_valid = 1; req_mode = VEC[i][10:7]; cur_mode = VEC[i][6:3];
            trans_busy = VEC[i][2]; lp_exit_fail = VEC[i][1];
            tick();
            chk($sformatf("R4 vec%0d tgt_valid", i), tgt_valid, VEC[i][0]);
            chk($sformatf("R4 vec%0d invalid bit", i), pend[0], !VEC[i][0]);
            if (VEC[i][0]) chk($sformatf("R4 vec%0d tgt_mode", i), tgt_mode, VEC[i][10:7]);
            req_valid = 0; trans_busy = 0; lp_exit_fail = 0;
            tick();
            chk($sformatf("R4 vec%0d pulse ends", i), tgt_valid, 0);
            clear(3'b111);
        end
        cur_mode = 4'd4;
        clear(3'b111);
        chk("R9 all cleared", pend, 0);

        // R10 mask and irq timing
        mask_wr = 1; mask_data = 3'b001; tick(); mask_wr = 0;
        chk("R10 mask load", mask, 3'b001);
        req_valid = 1; req_mode = 4'd11; tick(); req_valid = 0;
        chk("R10 pend set", pend[0], 1);
        chk("R10 irq not yet", irq, 0);
        tick();
        chk("R10 irq raised", irq, 1);
        clear(3'b001);
        chk("R9 invalid cleared", pend[0], 0);
        tick();
        chk("R10 irq dropped", irq, 0);
        mask_wr = 1; mask_data = 3'b000; tick(); mask_wr = 0;
        req_valid = 1; req_mode = 4'd13; tick(); req_valid = 0;
        tick();
        chk("R10 masked pend", pend[0], 1);
        chk("R10 masked irq", irq, 0);
        clear(3'b001);

        // R5/R7 hardware safe
        hw_safe_req = 1; tick();
        chk("R5 hw edge sets", pend[1], 1);
        clear(3'b010);
        chk("R7 clear ignored while held", pend[1], 1);
        hw_safe_req = 0; tick();
        clear(3'b010);
        chk("R7 clear after release", pend[1], 0);
        cur_mode = 4'd2; hw_safe_req = 1; tick();
        chk("R5 re-request in SAFE", pend[1], 1);
        hw_safe_req = 0; tick(); clear(3'b010);

        // R6 software safe
        sw_safe_req = 1; tick(); sw_safe_req = 0;
        chk("R6 tgt_valid", tgt_valid, 1);
        chk("R6 tgt_mode", tgt_mode, 4'd2);
        chk("R6 no fault bit", pend[1], 0);
        tick();
        chk("R6 still no fault bit", pend[1], 0);

        // R9 hw edge with clear in same cycle
        hw_safe_req = 1; clr_wr = 1; clr_data = 3'b010; tick();
        clr_wr = 0; clr_data = 0;
        chk("R9 safe set beats clear", pend[1], 1);
        hw_safe_req = 0; tick(); clear(3'b010);

        // R8 transition complete
        cur_mode = 4'd5; trans_busy = 1; tick(); trans_busy = 0; tick();
        chk("R8 complete into RUN1", pend[2], 1);
        clear(3'b100);
        chk("R9 complete cleared", pend[2], 0);
        cur_mode = 4'd8; trans_busy = 1; tick(); trans_busy = 0; tick();
        chk("R8 HALT0 suppressed", pend[2], 0);
        cur_mode = 4'd10; trans_busy = 1; tick(); trans_busy = 0; tick();
        chk("R8 STOP0 suppressed", pend[2], 0);
        cur_mode = 4'd6; trans_busy = 1; tick();
        trans_busy = 0; clr_wr = 1; clr_data = 3'b100; tick();
        clr_wr = 0; clr_data = 0;
        chk("R9 complete set beats clear", pend[2], 1);
        clear(3'b100);
        chk("R9 complete later cleared", pend[2], 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule